// File: doc/BRIEF.md
# Serial Message Loader with Length Prefix

This block takes a secret message arriving over an asynchronous serial line and fills an on-chip byte buffer for a later embedding engine. A receiver samples the line at sixteen times the bit rate and recovers eight-data-bit frames. A framing layer above it reads the opening two bytes of a transfer as the message length. It then writes each following byte to the next buffer address.

When the buffer holds as many bytes as the header declared, the block raises a start flag for the embedding engine. That flag stays high until reset. Frames whose stop bit is low are reported on a one-cycle error pulse and discarded. The oversampling rate comes from a clock divider parameter. The default gives 9600 baud from a 200 MHz clock.

Top module: `msg_loader`

## Requirements
- R1: After reset, `wr_en`, `embed_go` and `frame_err` are 0 and `msg_len` is 0.
- R2: A frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit, each bit lasting 16 sample ticks. Every data bit is sampled at its middle.
- R3: The first two good frames form the message length, most significant byte first. It appears on `msg_len` once the second byte has arrived.
- R4: A declared length above `BUF_DEPTH` (8192) is clamped, so `msg_len` shows `BUF_DEPTH`.
- R5: Each good frame after the header gives one `wr_en` pulse of one cycle. `wr_addr` counts up from 0 and `wr_data` holds the received byte.
- R6: `embed_go` rises in the same cycle as the write of the last declared byte. It never rises earlier and stays at 1 until reset.
- R7: Frames that arrive while `embed_go` is 1 produce no write.
- R8: A frame with a low stop bit gives a one-cycle `frame_err` pulse and no write. The frame does not advance the write address or the header count.
- R9: A declared length of 0 raises `embed_go` after the header, and no write takes place.
- R10: A low pulse on the line shorter than half a bit (fewer than 8 ticks) does not start a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | $clog2(BUF_DEPTH) | Buffer write address |
| wr_data | output | 8 | Buffer write byte |
| msg_len | output | $clog2(BUF_DEPTH+1) | Declared length after clamping |
| embed_go | output | 1 | Start flag for the embedding engine |
| frame_err | output | 1 | Pulse for a frame with a bad stop bit |

## Verification
Two events can fall in the same cycle: the write of the final message byte and the rise of the start flag. The bench declares a short length, so the last payload frame completes the message. On every clock, a behavioural model counts the observed write strobes. Each strobe must match the next queued address and byte. When a strobe brings the count up to the declared length, the flag must already be high in that same cycle, and the flag must never be high at any other count.

// File: rtl/msg_loader.sv
module msg_loader #(
  parameter int TICK_DIV  = 1302,
  parameter int BUF_DEPTH = 8192,
  localparam int AW = $clog2(BUF_DEPTH),
  localparam int LW = $clog2(BUF_DEPTH + 1),
  localparam int TW = $clog2(TICK_DIV + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic [LW-1:0] msg_len,
  output logic          embed_go,
  output logic          frame_err
);

  typedef enum logic [1:0] {S_START, S_DATA, S_STOP} rx_state_t;

  logic [1:0]    rx_sync;
  logic [TW-1:0] pre;
  rx_state_t     st;
  logic [3:0]    smp;
  logic [2:0]    bitn;
  logic [7:0]    shreg;
  logic          armed, byte_ok, byte_bad;
  logic [1:0]    hdr_n;
  logic [7:0]    hdr_hi;
  logic [LW-1:0] wcnt, len_c;

  wire rx_s = rx_sync[1];
  wire tick = (pre == TW'(TICK_DIV - 1));
  wire [15:0] hdr_full = {hdr_hi, shreg};

  always_comb
    if (32'(hdr_full) > BUF_DEPTH) len_c = LW'(BUF_DEPTH);
    else                           len_c = LW'(hdr_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_sync <= 2'b11;
      pre     <= '0;
    end else begin
      rx_sync <= {rx_sync[0], rxd};
      pre     <= tick ? '0 : pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_START; smp <= '0; bitn <= '0; shreg <= '0;
      armed <= 1'b0; byte_ok <= 1'b0; byte_bad <= 1'b0;
    end else begin
      byte_ok  <= 1'b0;
      byte_bad <= 1'b0;
      case (st)
        S_START:
          if (rx_s) begin
            smp <= '0; armed <= 1'b1;
          end else if (armed && tick) begin
            if (smp == 4'd7) begin
              st <= S_DATA; smp <= '0; bitn <= '0; armed <= 1'b0;
            end else smp <= smp + 1'b1;
          end
        S_DATA:
          if (tick) begin
            if (smp == 4'd15) begin
              shreg <= {rx_s, shreg[7:1]};
              smp   <= '0;
              if (bitn == 3'd7) st <= S_STOP;
              else bitn <= bitn + 1'b1;
            end else smp <= smp + 1'b1;
          end
        default:
          if (tick) begin
            if (smp == 4'd15) begin
              st <= S_START; smp <= '0;
              if (rx_s) byte_ok <= 1'b1;
              else      byte_bad <= 1'b1;
            end else smp <= smp + 1'b1;
          end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; msg_len <= '0;
      embed_go <= 1'b0; frame_err <= 1'b0;
      hdr_n <= '0; hdr_hi <= '0; wcnt <= '0;
    end else begin
      wr_en     <= 1'b0;
      frame_err <= byte_bad;
      if (byte_ok) begin
        if (hdr_n != 2'd2) begin
          hdr_hi <= shreg;
          hdr_n  <= hdr_n + 1'b1;
          if (hdr_n == 2'd1) begin
            msg_len <= len_c;
            if (len_c == '0) embed_go <= 1'b1;
          end
        end else if (!embed_go) begin
          wr_en   <= 1'b1;
          wr_addr <= wcnt[AW-1:0];
          wr_data <= shreg;
          wcnt    <= wcnt + 1'b1;
          if (wcnt + 1'b1 == msg_len) embed_go <= 1'b1;
        end
      end
    end
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (LW'(wr_addr) < msg_len)); // R5
  AST_GO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) embed_go |=> embed_go); // R6
  AST_NO_WR_AFTER_GO: assert property (@(posedge clk) disable iff (!rst_n) $past(embed_go) |-> !wr_en); // R7
  AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (!rst_n) msg_len <= LW'(BUF_DEPTH)); // R4
  AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> !wr_en); // R8
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R8

endmodule

// File: tb/msg_loader_test.sv
`timescale 1ns/1ps
module msg_loader_test;
  localparam int TDIV = 2;
  localparam int DEPTH = 8192;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic wr_en, embed_go, frame_err;
  logic [12:0] wr_addr;
  logic [7:0]  wr_data;
  logic [13:0] msg_len;

  msg_loader #(.TICK_DIV(TDIV), .BUF_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .msg_len(msg_len), .embed_go(embed_go), .frame_err(frame_err));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int mdl_len = 0, n_wr = 0, n_err = 0;
  int exp_addr[$];
  int exp_data[$];
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_en) begin
        n_wr++;
        if (exp_addr.size() == 0) check(1'b0, "R7 unexpected write", int'(wr_addr), -1);
        else begin
          int ea, ed;
          ea = exp_addr.pop_front();
          ed = exp_data.pop_front();
          check(int'(wr_addr) == ea, "R5 address", int'(wr_addr), ea);
          check(int'(wr_data) == ed, "R2 R5 data", int'(wr_data), ed);
        end
        if (n_wr == mdl_len) check(embed_go == 1'b1, "R6 go with last write", int'(embed_go), 1);
      end
      if (embed_go) check(n_wr == mdl_len, "R6 go only at full count", n_wr, mdl_len);
      if (frame_err) n_err++;
    end
  end

  task automatic do_reset(input int len);
    rst_n = 1'b0;
    rxd = 1'b1;
    exp_addr.delete();
    exp_data.delete();
    n_wr = 0; n_err = 0; mdl_len = len;
    repeat (4) @(negedge clk);
    check(wr_en == 1'b0 && embed_go == 1'b0 && frame_err == 1'b0, "R1 reset flags",
          int'({wr_en, embed_go, frame_err}), 0);
    check(msg_len == '0, "R1 reset length", int'(msg_len), 0);
    rst_n = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input bit stop_ok);
    rxd = 1'b0;
    repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      repeat (BITCLK) @(negedge clk);
    end
    rxd = stop_ok;
    repeat (BITCLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  task automatic glitch();
    rxd = 1'b0;
    repeat (4 * TDIV) @(negedge clk);
    rxd = 1'b1;
    repeat (BITCLK) @(negedge clk);
  endtask

  initial begin
    // three-byte message with a bad frame, a glitch and a trailing byte
    do_reset(3);
    send(8'h00, 1'b1);
    send(8'h03, 1'b1);
    check(int'(msg_len) == 3, "R3 length", int'(msg_len), 3);
    check(embed_go == 1'b0, "R6 not yet", int'(embed_go), 0);
    exp_addr.push_back(0); exp_data.push_back(8'hA5);
    send(8'hA5, 1'b1);
    glitch();
    check(n_wr == 1, "R10 glitch ignored", n_wr, 1);
    exp_addr.push_back(1); exp_data.push_back(8'h3C);
    send(8'h3C, 1'b1);
    send(8'h77, 1'b0);
    check(n_err == 1, "R8 error pulse", n_err, 1);
    check(n_wr == 2, "R8 byte dropped", n_wr, 2);
    exp_addr.push_back(2); exp_data.push_back(8'h81);
    send(8'h81, 1'b1);
    check(embed_go == 1'b1, "R6 go raised", int'(embed_go), 1);
    send(8'h55, 1'b1);
    check(n_wr == 3, "R7 no write after go", n_wr, 3);
    check(embed_go == 1'b1, "R6 go held", int'(embed_go), 1);
    check(exp_addr.size() == 0, "R5 all writes seen", exp_addr.size(), 0);

    // zero-length message
    do_reset(0);
    send(8'h00, 1'b1);
    check(embed_go == 1'b0, "R9 not after one byte", int'(embed_go), 0);
    send(8'h00, 1'b1);
    check(embed_go == 1'b1, "R9 go after header", int'(embed_go), 1);
    check(int'(msg_len) == 0, "R9 length zero", int'(msg_len), 0);
    send(8'h12, 1'b1);
    check(n_wr == 0, "R9 R7 no writes", n_wr, 0);

    // bad frame inside the header
    do_reset(2);
    send(8'hFF, 1'b0);
    check(n_err == 1, "R8 header error", n_err, 1);
    send(8'h00, 1'b1);
    send(8'h02, 1'b1);
    check(int'(msg_len) == 2, "R8 R3 header not advanced", int'(msg_len), 2);
    exp_addr.push_back(0); exp_data.push_back(8'h11);
    exp_addr.push_back(1); exp_data.push_back(8'h22);
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    check(embed_go == 1'b1 && n_wr == 2, "R6 go after two", n_wr, 2);

    // big-endian and clamping
    do_reset(258);
    send(8'h01, 1'b1);
    send(8'h02, 1'b1);
    check(int'(msg_len) == 258, "R3 big-endian", int'(msg_len), 258);
    do_reset(DEPTH);
    send(8'hFF, 1'b1);
    send(8'hFF, 1'b1);
    check(int'(msg_len) == DEPTH, "R4 clamp", int'(msg_len), DEPTH);
    check(embed_go == 1'b0, "R4 no go", int'(embed_go), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule